// File: doc/BRIEF.md
# SPI Controller Interrupt Status Logic

This block gathers the interrupt events of an SPI controller and turns them into one level interrupt line. Three event sources (transmit finished, receive data ready, receive overflow) arrive as one-cycle set pulses from the transfer engine and FIFO logic. Each pulse latches a bit in a raw status register. The raw bit stays set until software clears it by writing a one to the matching bit of an interrupt-clear register.

A control register carries three enable bits. These bits do not sit at the same positions as the raw bits they gate, so each enable is routed to its own source. The masked status is the raw status gated by the routed enables. The interrupt output is a registered OR of the masked status. The raw-status, masked-status and general-status addresses are read-only, and a write to any of them changes nothing. FIFO storage and the serial shifter sit outside this block.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A one on `ev_set_i[0]` (transmit done), `ev_set_i[1]` (receive ready) or `ev_set_i[2]` (receive overflow) sets raw status bit 0, 1 or 2 at the next clock edge. The bit then holds until it is cleared.
- R2: `masked_stat_o` equals `raw_stat_o` gated by the enables last written to the control register at address 0. Data bit 5 enables raw bit 0, data bit 4 enables raw bit 1, and data bit 6 enables raw bit 2. The masked status follows a control write from the next edge.
- R3: `irq_o` is high exactly when the masked status was nonzero in the previous cycle. It is a registered signal and lags the masked status by one cycle.
- R4: A write to the interrupt-clear register at address 3 clears each raw bit whose data bit (0, 1 or 2) is one. Raw bits whose data bit is zero are unchanged.
- R5: Writes to the read-only addresses 2, 8 and 9 leave the raw status, the enables and the interrupt unchanged.
- R6: While reset is active and after it is released, the raw status, the enables and `irq_o` are zero.
- R7: If a set pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set_i | input | 3 | Event set pulses: bit 0 transmit done, bit 1 receive ready, bit 2 overflow |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| raw_stat_o | output | 3 | Raw interrupt status |
| masked_stat_o | output | 3 | Raw status gated by routed enables |
| irq_o | output | 1 | Level interrupt request |

## Verification
Set pulses, clear writes and control writes all reach the raw status and the masked status at the first clock edge after they are driven. The interrupt line follows one edge after that, because it registers the masked status. The bench drives each cycle's stimulus between edges. It advances its reference model at the same edge the design updates, and it computes the expected interrupt from the model's masked value before that edge. It then compares all three outputs shortly after the edge. This keeps the one-cycle lag of the interrupt inside the model instead of in ad hoc delays.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_SRC    = 3;
    localparam int SRC_TXDONE = 0;
    localparam int SRC_RXRDY  = 1;
    localparam int SRC_OVF    = 2;

    // Control-register bit positions of the enables.
    localparam int EN_POS_TXDONE = 5;
    localparam int EN_POS_RXRDY  = 4;
    localparam int EN_POS_OVF    = 6;

    // Enable bit position for a given raw-status source index.
    function automatic int en_pos(input int src);
        case (src)
            SRC_TXDONE: en_pos = EN_POS_TXDONE;
            SRC_RXRDY:  en_pos = EN_POS_RXRDY;
            default:    en_pos = EN_POS_OVF;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               irq;
    } ctl_state_t;

endpackage

// File: rtl/spi_irq_en_router.sv
module spi_irq_en_router
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] en_o
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
        assign en_o[i] = wdata[en_pos(i)];
    end

endmodule

// File: rtl/spi_irq_raw_bank.sv
module spi_irq_raw_bank
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    logic [NUM_SRC-1:0] raw_d, raw_q;

    always_comb begin
        raw_d = raw_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (set_i[i]) begin
                raw_d[i] = 1'b1;
            end else if (clr_i[i]) begin
                raw_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

    assign raw_o = raw_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R1 / R7: a set pulse always lands, even against a clear
        p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> raw_o[i]);
        // R4: a clear without a set drops the bit
        p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !raw_o[i]);
        // R5: with no set and no clear the bit holds
        p_bit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(raw_o[i]));
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int ADR_CTRL  = 0,
    parameter int ADR_ICLR  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ev_set_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [2:0]         raw_stat_o,
    output logic [2:0]         masked_stat_o,
    output logic               irq_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(ADR_ICLR);

    ctl_state_t         st_d, st_q;
    logic [NUM_SRC-1:0] routed_en;
    logic [NUM_SRC-1:0] clr_bits;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] masked;

    spi_irq_en_router #(.DATA_W(DATA_W)) u_router (
        .wdata (wr_data_i),
        .en_o  (routed_en)
    );

    assign clr_bits = (wr_en_i && wr_addr_i == A_ICLR) ? wr_data_i[NUM_SRC-1:0] : '0;

    spi_irq_raw_bank u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_set_i),
        .clr_i (clr_bits),
        .raw_o (raw_q)
    );

    assign masked = raw_q & st_q.en;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked;
        if (wr_en_i && wr_addr_i == A_CTRL) begin
            st_d.en = routed_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_stat_o    = raw_q;
    assign masked_stat_o = masked;
    assign irq_o         = st_q.irq;

    // R3: interrupt follows the masked status one cycle later
    p_irq_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked_stat_o) |=> irq_o);
    p_irq_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked_stat_o) |=> !irq_o);
    // R2: enables change only through a control write
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == A_CTRL) |=> $stable(st_q.en));
    // R6: nothing is pending right after reset
    p_reset_clean_r6: assert property (@(posedge clk)
        !rst_n |=> (raw_stat_o == '0 && !irq_o));

endmodule

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ev_set_i;
    logic        wr_en_i;
    logic [3:0]  wr_addr_i;
    logic [31:0] wr_data_i;
    logic [2:0]  raw_stat_o;
    logic [2:0]  masked_stat_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [2:0] m_raw, m_en;
    logic       m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_set_i      (ev_set_i),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .raw_stat_o    (raw_stat_o),
        .masked_stat_o (masked_stat_o),
        .irq_o         (irq_o)
    );

    // Enable routing from the requirement: bit5->raw0, bit4->raw1, bit6->raw2
    function automatic logic [2:0] route(input logic [31:0] d);
        return {d[6], d[4], d[5]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1/R4/R7 raw", {29'd0, raw_stat_o}, {29'd0, m_raw});
        chk("R2 masked", {29'd0, masked_stat_o}, {29'd0, m_raw & m_en});
        chk("R3 irq", {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic step(input logic [2:0] s, input logic we, input logic [3:0] a,
                        input logic [31:0] d);
        logic [2:0] clr;
        ev_set_i  = s;
        wr_en_i   = we;
        wr_addr_i = a;
        wr_data_i = d;
        @(posedge clk);
        m_irq = |(m_raw & m_en);
        if (we && a == 4'd0) m_en = route(d);
        clr   = (we && a == 4'd3) ? d[2:0] : 3'b000;
        m_raw = (m_raw & ~clr) | s;
        #1;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; ev_set_i = '0; wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
        m_raw = '0; m_en = '0; m_irq = 0;
        // R6: pulses during reset have no effect
        ev_set_i = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        chk("R6 raw in reset", {29'd0, raw_stat_o}, 32'd0);
        chk("R6 irq in reset", {31'd0, irq_o}, 32'd0);
        ev_set_i = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R6 raw after reset", {29'd0, raw_stat_o}, 32'd0);
        chk("R6 masked after reset", {29'd0, masked_stat_o}, 32'd0);

        // R1: set each source, no enables yet -> no irq
        step(3'b001, 0, 4'd0, 0);
        step(3'b100, 0, 4'd0, 0);
        chk("R1 raw bits 0 and 2", {29'd0, raw_stat_o}, 32'd5);
        // R2: enable only transmit-done via bit 5
        step(3'b000, 1, 4'd0, 32'h0000_0020);
        chk("R2 txdone routed", {29'd0, masked_stat_o}, 32'd1);
        step(3'b000, 0, 4'd0, 0);
        chk("R3 irq one cycle later", {31'd0, irq_o}, 32'd1);
        // R2: bit 4 enables receive-ready only
        step(3'b010, 1, 4'd0, 32'h0000_0010);
        chk("R2 rxrdy routed", {29'd0, masked_stat_o}, 32'd2);
        // R5: writes of all ones to read-only addresses do nothing
        step(3'b000, 1, 4'd9, 32'hFFFF_FFFF);
        step(3'b000, 1, 4'd8, 32'hFFFF_FFFF);
        step(3'b000, 1, 4'd2, 32'hFFFF_FFFF);
        chk("R5 raw unchanged", {29'd0, raw_stat_o}, 32'd7);
        chk("R5 masked unchanged", {29'd0, masked_stat_o}, 32'd2);
        // R4: clear bit 1 only
        step(3'b000, 1, 4'd3, 32'h0000_0002);
        chk("R4 clear bit1", {29'd0, raw_stat_o}, 32'd5);
        step(3'b000, 0, 4'd0, 0);
        chk("R3 irq drops", {31'd0, irq_o}, 32'd0);
        // R7: set and clear on the same bit, set wins
        step(3'b100, 1, 4'd3, 32'h0000_0007);
        chk("R7 set wins", {29'd0, raw_stat_o}, 32'd4);
        // overflow enable via bit 6
        step(3'b000, 1, 4'd0, 32'h0000_0040);
        step(3'b000, 0, 4'd0, 0);
        chk("R3 irq from overflow", {31'd0, irq_o}, 32'd1);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic [2:0]  s;
            logic        we;
            logic [3:0]  a;
            logic [31:0] d;
            int          pick;
            s  = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            we = (($urandom % 3) == 0);
            pick = $urandom % 6;
            case (pick)
                0: a = 4'd0;
                1: a = 4'd3;
                2: a = 4'd2;
                3: a = 4'd8;
                4: a = 4'd9;
                default: a = 4'($urandom);
            endcase
            d = $urandom;
            step(s, we, a, d);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule